// File: doc/BRIEF.md
# CAN Fault-Confinement Error Tally

This block keeps the fault-confinement bookkeeping for a CAN protocol engine. It holds three things. The first is a transmit error count. The second is a receive error count, together with a flag that marks the receiver as error passive. The third is a separate 8-bit log of protocol errors. The engine reports four single-cycle event strobes: transmit error, receive error, successful transmit and successful receive. The block updates its counters on the next rising clock edge.

All state is exposed as one packed 32-bit status word. When software reads that word, the error log clears. A restricted-operation mode freezes the two confinement counters against errors. The log keeps counting in that mode, so errors seen while restricted are not lost. When an error arrives while the log is already full, the block raises a one-cycle overflow interrupt.

Top module: `canErrTally`

## Requirements
- R1: The status word carries the transmit count in bits 7:0, the receive count in bits 14:8, the passive flag in bit 15 and the error log in bits 23:16; bits 31:24 are always zero.
- R2: While reset is held and directly after it, the status word and the interrupt are zero.
- R3: The log adds one in every cycle that carries a transmit or a receive error strobe (one per cycle even if both are set). It stops at 255 and does not wrap.
- R4: When an error strobe arrives while the log holds 255 and no read occurs in that cycle, the interrupt is high for exactly the following cycle. The interrupt is low in every other case.
- R5: A read strobe returns the log value from before the read in that same cycle, and the log is zero in the next cycle. If a read and an error strobe coincide, the log is 1 in the next cycle and no interrupt fires.
- R6: With restricted mode high, error strobes leave the transmit count, the receive count and the passive flag unchanged, but still advance the log. Success strobes still decrement the counts.
- R7: A transmit error that is not suppressed adds 8 to the transmit count, saturating at 255. Otherwise a successful transmit subtracts 1, with a floor of 0. An error in the same cycle takes precedence.
- R8: A receive error that is not suppressed adds 1 to the receive count. Otherwise a successful receive subtracts 1, with a floor of 0. An error in the same cycle takes precedence.
- R9: The receive count holds at 127. A receive error at 127 sets the passive flag instead. The first successful receive while passive clears the flag and loads the receive count with 120.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrStb | input | 1 | Transmit error event |
| rxErrStb | input | 1 | Receive error event |
| txOkStb | input | 1 | Successful transmission event |
| rxOkStb | input | 1 | Successful reception event |
| restrictMode | input | 1 | Restricted-operation mode: errors do not move the confinement counters |
| statusRdStb | input | 1 | Status word read; clears the error log |
| statusWord | output | 32 | Packed counter and flag status |
| logOvfIrq | output | 1 | One-cycle pulse for an error seen while the log is full |

## Verification
Every counter field and the overflow interrupt are registered, so each is due in the first cycle after the rising edge that samples the strobe. The value returned by a read is due in the cycle of the read strobe itself. The driver applies each stimulus at a falling edge and pushes the predicted post-edge state into a queue. At the same moment it compares the pre-clear status for reads. The monitor pops one item per rising edge and compares it 1 ns after that edge, so every result is sampled in exactly its own cycle.

// File: rtl/canErrPkg.sv
package canErrPkg;
  localparam int STATUS_W = 32;

  typedef struct packed {
    logic tecAdd;
    logic tecSub;
    logic recAdd;
    logic recSub;
    logic logInc;
    logic logClr;
  } errStrobes_t;
endpackage

// File: rtl/canErrCtrl.sv
module canErrCtrl
  import canErrPkg::*;
(
  input  logic        txErrStb,
  input  logic        rxErrStb,
  input  logic        txOkStb,
  input  logic        rxOkStb,
  input  logic        restrictMode,
  input  logic        statusRdStb,
  output errStrobes_t stb
);
  logic txErrLive;
  logic rxErrLive;

  always_comb begin
    txErrLive  = txErrStb & ~restrictMode;
    rxErrLive  = rxErrStb & ~restrictMode;
    stb.tecAdd = txErrLive;
    stb.tecSub = txOkStb & ~txErrLive;
    stb.recAdd = rxErrLive;
    stb.recSub = rxOkStb & ~rxErrLive;
    stb.logInc = txErrStb | rxErrStb;
    stb.logClr = statusRdStb;
  end
endmodule

// File: rtl/canErrPath.sv
module canErrPath
  import canErrPkg::*;
#(
  parameter int TecW      = 8,
  parameter int RecW      = 7,
  parameter int LogW      = 8,
  parameter int TecStep   = 8,
  parameter int RecResume = 120
) (
  input  logic                clk,
  input  logic                rstN,
  input  errStrobes_t         stb,
  output logic [STATUS_W-1:0] statusWord,
  output logic                logOvfIrq
);
  localparam int RecLsb = TecW;
  localparam int PasBit = TecW + RecW;
  localparam int LogLsb = PasBit + 1;
  localparam logic [TecW-1:0] TecMax = '1;
  localparam logic [RecW-1:0] RecMax = '1;
  localparam logic [LogW-1:0] LogMax = '1;
  localparam logic [TecW:0]   TecStepW = (TecW+1)'(TecStep);
  localparam logic [RecW-1:0] RecResumeW = RecW'(RecResume);

  logic [TecW-1:0] tecQ;
  logic [RecW-1:0] recQ;
  logic            pasQ;
  logic [LogW-1:0] logQ;
  logic            irqQ;
  logic [TecW:0]   tecSum;
  logic [LogW-1:0] logBase;
  logic [LogW-1:0] logNext;

  always_comb begin
    tecSum  = {1'b0, tecQ} + TecStepW;
    logBase = stb.logClr ? '0 : logQ;
    logNext = (stb.logInc && logBase != LogMax) ? logBase + 1'b1 : logBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tecQ <= '0;
      recQ <= '0;
      pasQ <= 1'b0;
      logQ <= '0;
      irqQ <= 1'b0;
    end else begin
      if (stb.tecAdd) begin
        tecQ <= (tecSum > {1'b0, TecMax}) ? TecMax : tecSum[TecW-1:0];
      end else if (stb.tecSub && tecQ != '0) begin
        tecQ <= tecQ - 1'b1;
      end

      if (stb.recAdd) begin
        if (recQ == RecMax) pasQ <= 1'b1;
        else recQ <= recQ + 1'b1;
      end else if (stb.recSub) begin
        if (pasQ) begin
          pasQ <= 1'b0;
          recQ <= RecResumeW;
        end else if (recQ != '0) begin
          recQ <= recQ - 1'b1;
        end
      end

      logQ <= logNext;
      irqQ <= stb.logInc & ~stb.logClr & (logQ == LogMax);
    end
  end

  always_comb begin
    statusWord                      = '0;
    statusWord[TecW-1:0]            = tecQ;
    statusWord[RecLsb +: RecW]      = recQ;
    statusWord[PasBit]              = pasQ;
    statusWord[LogLsb +: LogW]      = logQ;
  end

  assign logOvfIrq = irqQ;
endmodule

// File: rtl/canErrTally.sv
module canErrTally #(
  parameter int TecW      = 8,
  parameter int RecW      = 7,
  parameter int LogW      = 8,
  parameter int TecStep   = 8,
  parameter int RecResume = 120
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txErrStb,
  input  logic        rxErrStb,
  input  logic        txOkStb,
  input  logic        rxOkStb,
  input  logic        restrictMode,
  input  logic        statusRdStb,
  output logic [31:0] statusWord,
  output logic        logOvfIrq
);
  canErrPkg::errStrobes_t stb;

  canErrCtrl u_ctrl (
    .txErrStb    (txErrStb),
    .rxErrStb    (rxErrStb),
    .txOkStb     (txOkStb),
    .rxOkStb     (rxOkStb),
    .restrictMode(restrictMode),
    .statusRdStb (statusRdStb),
    .stb         (stb)
  );

  canErrPath #(
    .TecW     (TecW),
    .RecW     (RecW),
    .LogW     (LogW),
    .TecStep  (TecStep),
    .RecResume(RecResume)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .statusWord(statusWord),
    .logOvfIrq (logOvfIrq)
  );
endmodule

// File: rtl/canErrTallyChk.sv
module canErrTallyChk #(
  parameter int TecW = 8,
  parameter int RecW = 7,
  parameter int LogW = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        txErrStb,
  input logic        rxErrStb,
  input logic        txOkStb,
  input logic        rxOkStb,
  input logic        restrictMode,
  input logic        statusRdStb,
  input logic [31:0] statusWord,
  input logic        logOvfIrq
);
  localparam int LogLsb = TecW + RecW + 1;
  localparam int CntTop = TecW + RecW;
  localparam logic [LogW-1:0] LogFull = '1;

  logic [LogW-1:0] logF;
  logic            anyErr;
  assign logF   = statusWord[LogLsb +: LogW];
  assign anyErr = txErrStb | rxErrStb;

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:LogLsb+LogW] == '0);

  a_r3_log_holds_full: assert property (@(posedge clk) disable iff (!rstN)
    (logF == LogFull && anyErr && !statusRdStb) |=> logF == LogFull);

  a_r4_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    (logF == LogFull && anyErr && !statusRdStb) |=> logOvfIrq);

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    logOvfIrq |-> ($past(logF) == LogFull && $past(anyErr) && !$past(statusRdStb)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdStb && !anyErr) |=> logF == '0);

  a_r5_read_with_err: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdStb && anyErr) |=> (logF == LogW'(1) && !logOvfIrq));

  a_r6_frozen_counts: assert property (@(posedge clk) disable iff (!rstN)
    (restrictMode && anyErr && !txOkStb && !rxOkStb) |=> $stable(statusWord[CntTop:0]));
endmodule

bind canErrTally canErrTallyChk #(.TecW(TecW), .RecW(RecW), .LogW(LogW)) u_chk (.*);

// File: tb/sim_canErrTally.sv
`timescale 1ns/1ps
module sim_canErrTally;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txErrStb = 1'b0, rxErrStb = 1'b0, txOkStb = 1'b0, rxOkStb = 1'b0;
  logic        restrictMode = 1'b0, statusRdStb = 1'b0;
  logic [31:0] statusWord;
  logic        logOvfIrq;

  always #2 clk = ~clk;

  canErrTally u0 (.*);

  typedef struct {
    logic [31:0] word;
    logic        irq;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int mTec = 0, mRec = 0, mLog = 0;
  bit mPas = 1'b0;

  function automatic logic [31:0] packModel();
    return {8'h00, 8'(mLog), mPas, 7'(mRec), 8'(mTec)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit r, input bit to, input bit ro,
                      input bit rm, input bit rd, input string tag);
    expItem_t it;
    bit err;
    bit irqN;
    @(negedge clk);
    txErrStb = t; rxErrStb = r; txOkStb = to; rxOkStb = ro;
    restrictMode = rm; statusRdStb = rd;
    #0.1;
    if (rd) check(statusWord === packModel(), "R5 read value", statusWord, packModel());
    err = t | r;
    if (t && !rm) mTec = (mTec + 8 > 255) ? 255 : mTec + 8;
    else if (to && mTec > 0) mTec--;
    if (r && !rm) begin
      if (mRec == 127) mPas = 1'b1; else mRec++;
    end else if (ro) begin
      if (mPas) begin mPas = 1'b0; mRec = 120; end
      else if (mRec > 0) mRec--;
    end
    irqN = err && !rd && mLog == 255;
    if (rd) mLog = 0;
    if (err && mLog < 255) mLog++;
    it.word = packModel();
    it.irq  = irqN;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(statusWord === e.word, e.tag, statusWord, e.word);
        check(logOvfIrq === e.irq, {e.tag, " irq"}, {31'b0, logOvfIrq}, {31'b0, e.irq});
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    check(statusWord === 32'h0, "R2 reset word", statusWord, 32'h0);
    check(logOvfIrq === 1'b0, "R2 reset irq", {31'b0, logOvfIrq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R2 after reset");
    // R7: increments, decrements, precedence, floor, saturation
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, "R7 tx error");
    for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 0, 0, "R7 tx ok");
    step(1, 0, 1, 0, 0, 0, "R7 error beats ok");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 0, 0, "R7 tx ok floor");
    for (int i = 0; i < 33; i++) step(1, 0, 0, 0, 0, 0, "R7 tx saturate");
    step(1, 1, 0, 0, 0, 0, "R3 both errors count once");
    #3;
    check(statusWord[31:24] === 8'h0, "R1 upper bits zero", {24'h0, statusWord[31:24]}, 32'h0);
    // R5: read clears; read with error gives one
    step(0, 0, 0, 0, 0, 1, "R5 read clear");
    step(0, 1, 0, 0, 0, 1, "R5 read with error");
    // R8: receive count
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, "R8 rx error");
    step(0, 1, 0, 1, 0, 0, "R8 error beats ok");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0, "R8 rx ok floor");
    // R9: hold at top, passive, resume
    for (int i = 0; i < 130; i++) step(0, 1, 0, 0, 0, 0, "R9 rx climb");
    step(0, 0, 0, 1, 0, 0, "R9 leave passive");
    step(0, 0, 0, 1, 0, 0, "R9 after resume");
    // R6: restricted mode
    step(1, 0, 0, 0, 1, 0, "R6 tx error frozen");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, 0, "R6 rx error frozen");
    step(1, 1, 0, 0, 1, 0, "R6 both frozen");
    step(0, 0, 1, 1, 1, 0, "R6 ok still counts");
    // R3 and R4: fill the log, overflow pulses
    step(0, 0, 0, 0, 0, 1, "R5 read before fill");
    for (int i = 0; i < 255; i++) step(0, 1, 0, 0, 1, 0, "R3 fill log");
    step(1, 0, 0, 0, 1, 0, "R4 overflow pulse");
    step(0, 0, 0, 0, 1, 0, "R4 pulse ends");
    step(0, 1, 0, 0, 1, 0, "R4 second overflow");
    step(0, 1, 0, 0, 1, 1, "R4 read suppresses pulse");
    for (int i = 0; i < 254; i++) step(0, 1, 0, 0, 1, 0, "R3 refill log");
    step(0, 0, 0, 0, 0, 0, "R3 full idle");
    step(0, 0, 0, 0, 0, 1, "R5 read full log");
    step(0, 0, 0, 0, 0, 0, "R2 idle end");
    repeat (3) @(posedge clk);
    #1;
    finish();
  end
endmodule